// File: doc/BRIEF.md
# Asynchronous SRAM Word Read Controller

This block turns single-word read requests from synchronous logic into read cycles on an external asynchronous SRAM. The SRAM has a 32-bit data bus, a 19-bit word address, a split chip enable (one active-low pin and one active-high pin), a separate active-low output enable and an active-low write enable. The SRAM also has an error flag output, driven by its built-in error correction logic. A request carries a word address on a valid/ready handshake. The controller drives the enables and the address, then keeps the address still for a parameterised number of clock cycles. It then samples the data bus and the error flag on the same edge and returns both as a one-cycle response.

Two parameters set the timing. One is the access time, counted in clock cycles from the moment the enables and the address have all settled. The other is the minimum spacing between address changes. The controller holds each address for the larger of the two. When a new request arrives in the same cycle as a response, the enables stay on and only the address moves. When no request follows, the enables are released. The controller never writes.

Top module: `sram_rd_ctrl`

## Requirements
- R1: After reset, and whenever the controller has been idle for at least one cycle, `mem_ce_n`=1, `mem_ce`=0, `mem_oe_n`=1, `req_ready`=1 and `rsp_valid`=0.
- R2: In the cycle after a request is accepted (`req_valid` and `req_ready` both high at a clock edge), `mem_ce_n`=0, `mem_ce`=1 and `mem_oe_n`=0, and `mem_addr` equals the accepted address.
- R3: `mem_we_n` is 1 at all times.
- R4: `req_ready` is 0 from the cycle after acceptance until the response cycle. It is 1 in the cycle where `rsp_valid` is 1.
- R5: While a read is in progress, `mem_addr` and the enables do not change, and a request presented in that time is ignored.
- R6: `rsp_valid` is high for exactly one cycle. That cycle follows the HOLD-th clock edge after the acceptance edge, where HOLD = max(ACCESS_CYC, CYCLE_CYC).
- R7: `rsp_data` and `rsp_err` equal `mem_dq` and `mem_err` as sampled on that HOLD-th edge. On that edge the address and enables have been held for HOLD cycles (`rsp_err`=1 means the memory reported an error).
- R8: A request accepted in the response cycle keeps all three enables asserted without a gap, and only `mem_addr` changes.
- R9: If no request is accepted in the response cycle, the enables are deasserted in the following cycle.
- R10: Two successive changes of `mem_addr` are at least CYCLE_CYC clock cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | ADDR_W (19) | Word address of the request |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_data | output | DATA_W (32) | Captured data word |
| rsp_err | output | 1 | Captured error flag, 1 = error reported |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_ce | output | 1 | Memory chip enable, active high |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low, held high |
| mem_addr | output | ADDR_W (19) | Memory word address |
| mem_dq | input | DATA_W (32) | Memory data bus |
| mem_err | input | 1 | Memory error flag |

## Verification
The memory model in the bench returns a poison word with the error flag set until the address and enables have been stable for the access time. Early sampling therefore shows up as wrong data, and late or early sampling also shows up in the measured latency. The bench uses an access time shorter than the cycle time, so a design that waits only for the access time can be told apart from one that waits for the larger of the two. Random addresses are mixed with the all-zero and all-one addresses and with bit patterns that toggle the error flag. Reads are issued either back to back or with idle gaps, which separates the enable-holding path from the release path. Requests presented while a read is busy use a different address, so any wrongly accepted request would move the address bus or corrupt the returned word.

// File: rtl/sram_rd_pkg.sv
package sram_rd_pkg;

   typedef enum logic [0:0] {
      RD_IDLE = 1'b0,
      RD_WAIT = 1'b1
   } rd_state_e;

   function automatic int hold_cycles(input int access_cyc, input int cycle_cyc);
      return (access_cyc > cycle_cyc) ? access_cyc : cycle_cyc;
   endfunction

endpackage

// File: rtl/sram_rd_timer.sv
module sram_rd_timer #(
   parameter int HOLD = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic done
);
   localparam int CW = (HOLD < 2) ? 1 : $clog2(HOLD);
   localparam logic [CW-1:0] START = CW'(HOLD - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= START;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign done = (cnt_q == '0);

   assert_count_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= START);

endmodule

// File: rtl/sram_rd_pins.sv
module sram_rd_pins #(
   parameter int ADDR_W = 19
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              open_cyc,
   input  logic              close_cyc,
   input  logic [ADDR_W-1:0] addr_in,
   output logic              mem_ce_n,
   output logic              mem_ce,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [ADDR_W-1:0] mem_addr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_ce_n <= 1'b1;
      end else if (open_cyc) begin
         mem_ce_n <= 1'b0;
      end else if (close_cyc) begin
         mem_ce_n <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_ce <= 1'b0;
      end else if (open_cyc) begin
         mem_ce <= 1'b1;
      end else if (close_cyc) begin
         mem_ce <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_oe_n <= 1'b1;
      end else if (open_cyc) begin
         mem_oe_n <= 1'b0;
      end else if (close_cyc) begin
         mem_oe_n <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr <= '0;
      end else if (open_cyc) begin
         mem_addr <= addr_in;
      end
   end

   assign mem_we_n = 1'b1;

   assert_enable_pair_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_ce_n == !mem_ce) && (mem_oe_n == mem_ce_n));

   assert_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_n);

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
   parameter int DATA_W     = 32,
   parameter bit RESET_DATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_en,
   input  logic [DATA_W-1:0] dq_in,
   input  logic              err_in,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rsp_err
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
      end else begin
         rsp_valid <= cap_en;
      end
   end

   generate
      if (RESET_DATA) begin : g_rst_data
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rsp_data <= '0;
               rsp_err  <= 1'b0;
            end else if (cap_en) begin
               rsp_data <= dq_in;
               rsp_err  <= err_in;
            end
         end
      end else begin : g_free_data
         always_ff @(posedge clk) begin
            if (cap_en) begin
               rsp_data <= dq_in;
               rsp_err  <= err_in;
            end
         end
      end
   endgenerate

   assert_rsp_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/sram_rd_ctrl.sv
module sram_rd_ctrl
   import sram_rd_pkg::*;
#(
   parameter int ADDR_W     = 19,
   parameter int DATA_W     = 32,
   parameter int ACCESS_CYC = 2,
   parameter int CYCLE_CYC  = 2,
   parameter bit RESET_DATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rsp_err,
   output logic              mem_ce_n,
   output logic              mem_ce,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_dq,
   input  logic              mem_err
);
   localparam int HOLD = hold_cycles(ACCESS_CYC, CYCLE_CYC);

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("sram_rd_ctrl: bus widths must be positive");
      end
      if (ACCESS_CYC < 1 || CYCLE_CYC < 1) begin : g_bad_timing
         $error("sram_rd_ctrl: timing parameters must be at least one cycle");
      end
      if (HOLD > 200) begin : g_bad_hold
         $error("sram_rd_ctrl: hold window exceeds supported range");
      end
   endgenerate

   rd_state_e state_q, state_d;
   logic      accept;
   logic      done;
   logic      cap_en;
   logic      close_cyc;

   assign req_ready = (state_q == RD_IDLE);
   assign accept    = req_valid && req_ready;
   assign cap_en    = (state_q == RD_WAIT) && done;
   assign close_cyc = (state_q == RD_IDLE) && !accept;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         RD_IDLE: if (accept) state_d = RD_WAIT;
         RD_WAIT: if (done)   state_d = RD_IDLE;
         default:             state_d = RD_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= RD_IDLE;
      else        state_q <= state_d;
   end

   sram_rd_timer #(.HOLD(HOLD)) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .load (accept),
      .done (done)
   );

   sram_rd_pins #(.ADDR_W(ADDR_W)) u_pins (
      .clk      (clk),
      .rst_n    (rst_n),
      .open_cyc (accept),
      .close_cyc(close_cyc),
      .addr_in  (req_addr),
      .mem_ce_n (mem_ce_n),
      .mem_ce   (mem_ce),
      .mem_oe_n (mem_oe_n),
      .mem_we_n (mem_we_n),
      .mem_addr (mem_addr)
   );

   sram_rd_capture #(.DATA_W(DATA_W), .RESET_DATA(RESET_DATA)) u_capture (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_en   (cap_en),
      .dq_in    (mem_dq),
      .err_in   (mem_err),
      .rsp_valid(rsp_valid),
      .rsp_data (rsp_data),
      .rsp_err  (rsp_err)
   );

   // Cycles elapsed since the last accepted request; saturates.
   logic [7:0] since_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                since_q <= 8'hFF;
      else if (accept)           since_q <= 8'd0;
      else if (since_q != 8'hFF) since_q <= since_q + 8'd1;
   end

   assert_pins_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (!mem_ce_n && mem_ce && !mem_oe_n && mem_addr == $past(req_addr)));

   assert_ready_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !req_ready);

   assert_ready_at_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> req_ready);

   assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == RD_WAIT) |=> ($stable(mem_addr) && !mem_ce_n && !mem_oe_n));

   assert_capture_late_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cap_en |-> (32'(since_q) >= HOLD - 1));

   assert_idle_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      close_cyc |=> (mem_ce_n && !mem_ce && mem_oe_n));

   assert_addr_spacing_R10: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> (32'(since_q) >= CYCLE_CYC - 1));

endmodule

// File: tb/sram_rd_ctrl_test.sv
module sram_rd_ctrl_test;
   localparam int ACC  = 3;
   localparam int CYC  = 4;
   localparam int HOLD = (ACC > CYC) ? ACC : CYC;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [18:0] req_addr = '0;
   logic        rsp_valid;
   logic [31:0] rsp_data;
   logic        rsp_err;
   logic        mem_ce_n, mem_ce, mem_oe_n, mem_we_n;
   logic [18:0] mem_addr;
   logic [31:0] mem_dq;
   logic        mem_err;

   int tests = 0;
   int fails = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   function automatic logic [31:0] exp_word(input logic [18:0] a);
      return {a[7:0], a ^ 19'h2A5C3, a[4:0]};
   endfunction

   function automatic logic exp_err(input logic [18:0] a);
      return ^a[5:0];
   endfunction

   sram_rd_ctrl #(.ACCESS_CYC(ACC), .CYCLE_CYC(CYC)) uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
      .mem_ce_n(mem_ce_n), .mem_ce(mem_ce), .mem_oe_n(mem_oe_n),
      .mem_we_n(mem_we_n), .mem_addr(mem_addr),
      .mem_dq(mem_dq), .mem_err(mem_err)
   );

   // Memory model: valid data only after ACC stable cycles.
   logic [18:0] seen_addr = '0;
   logic        seen_en = 1'b0;
   int          stab = 0;
   int          gap = 1000;
   int          bad_gap = 0;
   wire         en = !mem_ce_n && mem_ce && !mem_oe_n && mem_we_n;

   always @(negedge clk) begin
      if (mem_addr !== seen_addr || en !== seen_en) stab <= 1;
      else if (stab < 1000) stab <= stab + 1;
      if (mem_addr !== seen_addr) begin
         if (gap < CYC) bad_gap <= bad_gap + 1;
         gap <= 1;
      end else if (gap < 1000) begin
         gap <= gap + 1;
      end
      seen_addr <= mem_addr;
      seen_en   <= en;
   end

   assign mem_dq  = (en && stab >= ACC) ? exp_word(mem_addr) : 32'hBAD0_BAD0;
   assign mem_err = (en && stab >= ACC) ? exp_err(mem_addr) : 1'b1;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, expv);
      end
   endtask

   // Called at a negedge with req_ready high.
   task automatic issue(input logic [18:0] a);
      req_valid = 1'b1;
      req_addr  = a;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk(!req_ready, "R4 ready low after accept", 32'(req_ready), 0);
      chk(!mem_ce_n && mem_ce && !mem_oe_n, "R2 enables asserted",
          {29'd0, mem_ce_n, mem_ce, mem_oe_n}, 32'b010);
      chk(mem_addr == a, "R2 address driven", 32'(mem_addr), 32'(a));
   endtask

   task automatic finish_rd(input logic [18:0] a, input bit poke);
      int  n = 0;
      bit  held = 1'b1;
      while (!rsp_valid && n < 100) begin
         if (poke) begin
            req_valid = 1'b1;
            req_addr  = ~a;
         end
         @(negedge clk);
         n++;
         if (!rsp_valid && (mem_addr != a || mem_ce_n)) held = 1'b0;
      end
      req_valid = 1'b0;
      chk(held && mem_addr == a, "R5 address held while busy", 32'(mem_addr), 32'(a));
      chk(n == HOLD, "R6 response latency", 32'(n), 32'(HOLD));
      chk(rsp_data == exp_word(a), "R7 data", rsp_data, exp_word(a));
      chk(rsp_err == exp_err(a), "R7 error flag", 32'(rsp_err), 32'(exp_err(a)));
      chk(req_ready, "R4 ready in response cycle", 32'(req_ready), 1);
      chk(mem_we_n, "R3 write enable high", 32'(mem_we_n), 1);
      chk(!mem_ce_n && mem_ce && !mem_oe_n, "R8 enables kept in response cycle",
          {29'd0, mem_ce_n, mem_ce, mem_oe_n}, 32'b010);
   endtask

   task automatic go_idle();
      @(negedge clk);
      chk(mem_ce_n && !mem_ce && mem_oe_n, "R9 enables released",
          {29'd0, mem_ce_n, mem_ce, mem_oe_n}, 32'b101);
      chk(!rsp_valid, "R6 single-cycle response", 32'(rsp_valid), 0);
      chk(req_ready, "R1 idle ready", 32'(req_ready), 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         fails++;
         tests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [18:0] a;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      chk(mem_ce_n && !mem_ce && mem_oe_n && mem_we_n, "R1 reset pins",
          {28'd0, mem_ce_n, mem_ce, mem_oe_n, mem_we_n}, 32'b1011);
      chk(req_ready && !rsp_valid, "R1 reset handshake",
          {30'd0, req_ready, rsp_valid}, 32'b10);
      rst_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk(mem_ce_n && req_ready, "R1 idle after reset", {30'd0, mem_ce_n, req_ready}, 32'b11);

      // Directed: boundary addresses, one isolated, then back to back.
      issue(19'h00000);
      finish_rd(19'h00000, 1'b0);
      go_idle();
      issue(19'h7FFFF);
      finish_rd(19'h7FFFF, 1'b1);
      issue(19'h00001);              // back-to-back, R8
      finish_rd(19'h00001, 1'b0);
      issue(19'h2AAAA);
      finish_rd(19'h2AAAA, 1'b1);
      go_idle();

      // Random mix of gaps, back-to-back and busy pokes.
      for (int i = 0; i < 60; i++) begin
         a = 19'($urandom);
         issue(a);
         finish_rd(a, ($urandom % 3) == 0);
         if ($urandom % 2) begin
            go_idle();
            repeat ($urandom % 3) @(negedge clk);
         end
      end
      go_idle();

      chk(bad_gap == 0, "R10 address change spacing", 32'(bad_gap), 0);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule